// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block runs a single analog-to-digital conversion. When it is idle and sees a start request, it steps through four phases in a fixed order. First the input is sampled onto a capacitor. Then the buffered sample is transferred to the DAC array. Next comes a direct charge of the DAC array from the input. Last is a successive-approximation resolution of ten trials. Each phase drives its own strobe to the analog switches, and only one strobe is active at a time. A conversion clock enable paces every phase. The clock edges where the enable is low do not count.

Two settings are captured with each start request. A 2-bit length field selects the duration of the direct-charge phase. A bypass bit skips the sampling and transfer phases. The block also contains a SAR register. It presents each trial code to an external comparator and keeps or drops the trial bit according to the comparator's answer. At the end of a conversion the block raises a one-cycle done pulse and loads the finished code into a result register that holds its value. A busy flag covers the whole conversion.

Top module: `adc_phase_seq`

## Requirements
- R1: While reset (rst_n low, asynchronous) is active and just after it, busy, done and all four strobes are 0 and result is 0.
- R2: A start that is high at a clock edge while busy is 0 is accepted whether or not ce is high. busy is 1 from that edge on. With bypass 0, the first phase is the input-sample phase (strb_sample).
- R3: Without bypass, the phases run in the order sample, transfer, direct charge, resolution, for 2, 4, N and 10 enabled cycles. The conversion therefore lasts 16+N enabled cycles.
- R4: len_sel selects N: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16 cycles.
- R5: With bypass 1, the conversion starts in the direct-charge phase (strb_direct). N is raised to at least 4, and the total is max(N,4)+10 enabled cycles.
- R6: While busy, exactly one of strb_sample, strb_xfer, strb_direct and strb_sar is high. While idle, all four are low.
- R7: Phases and SAR trials advance only at edges where ce is high. An edge with ce low leaves the strobes and trial_code unchanged.
- R8: The SAR resolves MSB first. In resolution step k (k=0..9), trial_code equals the bits kept so far with bit 9-k also set, so the first trial is 512. cmp_hi=1 at the enabled edge that ends the step keeps that bit, and 0 clears it. With the comparator cmp_hi = (analog >= trial_code), the result equals the analog code.
- R9: done is high for exactly one cycle, directly after the edge that completes the last resolution step. result updates on that same edge and otherwise holds its value. busy is low while done is high.
- R10: A start request while busy is ignored, including any len_sel or bypass value that comes with it. The running conversion keeps its length and its result.
- R11: A start that arrives in the cycle when done is high is accepted. The next cycle shows busy 1 and done 0, and result still holds the previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Conversion clock enable |
| start | input | 1 | Start request |
| len_sel | input | 2 | Direct-charge length select |
| bypass | input | 1 | Skip sample and transfer phases |
| cmp_hi | input | 1 | Comparator: analog input at or above trial code |
| trial_code | output | RES_BITS | Code presented to the DAC and comparator |
| strb_sample | output | 1 | Input connected to sample capacitor |
| strb_xfer | output | 1 | Buffered sample driven to DAC array |
| strb_direct | output | 1 | Input charges DAC array directly |
| strb_sar | output | 1 | SAR trial in progress |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_BITS | Last finished conversion code |

## Verification
Two things can happen in the same cycle: the done pulse that ends one conversion, and the acceptance of a new start request. The bench provokes this by raising start in the very cycle where done is high after a conversion. It checks that the next cycle shows busy high and done low, and that the result still holds the old code until the new conversion completes with its own correct code and cycle count. A second overlap is also tested. A start request with different settings is injected in the middle of a busy conversion, and the bench confirms that the enabled-cycle count and the result are unaffected.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_XFER,
        PH_DIRECT,
        PH_RESOLVE
    } phase_e;

    // Direct-charge length: 2 shifted by the select field, raised to a floor in bypass.
    function automatic int unsigned direct_len(logic [1:0] sel, logic byp, int unsigned byp_min);
        int unsigned n;
        n = 32'd2 << sel;
        if (byp && (n < byp_min)) n = byp_min;
        return n;
    endfunction

endpackage

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned INIT_CYC = 2,
    parameter int unsigned XFER_CYC = 4,
    parameter int unsigned RES_BITS = 10,
    parameter int unsigned BYP_MIN  = 4,
    parameter int unsigned CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             start_i,
    input  logic [1:0]       len_sel_i,
    input  logic             bypass_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] step_o,
    output logic             res_step_o,
    output logic             res_last_o
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dlen;
    } ctrl_t;

    ctrl_t            s_d, s_q;
    logic [CNT_W-1:0] cur_len;
    logic             at_end;

    always_comb begin
        case (s_q.ph)
            PH_SAMPLE: cur_len = CNT_W'(INIT_CYC);
            PH_XFER:   cur_len = CNT_W'(XFER_CYC);
            PH_DIRECT: cur_len = s_q.dlen;
            default:   cur_len = CNT_W'(RES_BITS);
        endcase
        at_end = (s_q.cnt == cur_len - 1'b1);

        s_d = s_q;
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                s_d.cnt  = '0;
                s_d.dlen = CNT_W'(direct_len(len_sel_i, bypass_i, BYP_MIN));
                s_d.ph   = bypass_i ? PH_DIRECT : PH_SAMPLE;
            end
        end else if (ce_i) begin
            if (at_end) begin
                s_d.cnt = '0;
                case (s_q.ph)
                    PH_SAMPLE: s_d.ph = PH_XFER;
                    PH_XFER:   s_d.ph = PH_DIRECT;
                    PH_DIRECT: s_d.ph = PH_RESOLVE;
                    default:   s_d.ph = PH_IDLE;
                endcase
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, dlen: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o    = s_q.ph;
    assign step_o     = s_q.cnt;
    assign res_step_o = (s_q.ph == PH_RESOLVE) && ce_i;
    assign res_last_o = res_step_o && at_end;

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int unsigned RES_BITS = 10,
    parameter int unsigned CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                active_i,
    input  logic                step_i,
    input  logic                last_i,
    input  logic [CNT_W-1:0]    idx_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);

    typedef struct packed {
        logic [RES_BITS-1:0] sar;
        logic [RES_BITS-1:0] res;
        logic                done;
    } sar_t;

    sar_t                s_d, s_q;
    logic [RES_BITS-1:0] probe;

    always_comb begin
        for (int b = 0; b < RES_BITS; b++) begin
            probe[b] = (idx_i == CNT_W'(RES_BITS - 1 - b));
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = last_i;
        if (clear_i) begin
            s_d.sar = '0;
        end else if (step_i) begin
            s_d.sar = (s_q.sar & ~probe) | (probe & {RES_BITS{cmp_i}});
        end
        if (last_i) s_d.res = s_d.sar;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sar: '0, res: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trial_o  = active_i ? (s_q.sar | probe) : s_q.sar;
    assign result_o = s_q.res;
    assign done_o   = s_q.done;

endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_BITS = 10,
    parameter int unsigned INIT_CYC = 2,
    parameter int unsigned XFER_CYC = 4,
    parameter int unsigned BYP_MIN  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                start,
    input  logic [1:0]          len_sel,
    input  logic                bypass,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] trial_code,
    output logic                strb_sample,
    output logic                strb_xfer,
    output logic                strb_direct,
    output logic                strb_sar,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result
);

    localparam int unsigned LEN_MAX = 16;
    localparam int unsigned M1      = (LEN_MAX > RES_BITS) ? LEN_MAX : RES_BITS;
    localparam int unsigned M2      = (M1 > INIT_CYC) ? M1 : INIT_CYC;
    localparam int unsigned M3      = (M2 > XFER_CYC) ? M2 : XFER_CYC;
    localparam int unsigned M4      = (M3 > BYP_MIN) ? M3 : BYP_MIN;
    localparam int unsigned CNT_W   = $clog2(M4 + 1);
    localparam int unsigned N_STRB  = 4;
    localparam phase_e STRB_PH [N_STRB] = '{PH_SAMPLE, PH_XFER, PH_DIRECT, PH_RESOLVE};

    phase_e             phase;
    logic [CNT_W-1:0]   step;
    logic               res_step, res_last, accept;
    logic [N_STRB-1:0]  strb;

    adc_phase_ctrl #(
        .INIT_CYC(INIT_CYC), .XFER_CYC(XFER_CYC), .RES_BITS(RES_BITS),
        .BYP_MIN(BYP_MIN), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .start_i(start),
        .len_sel_i(len_sel), .bypass_i(bypass), .phase_o(phase),
        .step_o(step), .res_step_o(res_step), .res_last_o(res_last)
    );

    assign busy   = (phase != PH_IDLE);
    assign accept = start && !busy;

    adc_sar_reg #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) sar_i (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .active_i(strb[3]),
        .step_i(res_step), .last_i(res_last), .idx_i(step), .cmp_i(cmp_hi),
        .trial_o(trial_code), .result_o(result), .done_o(done)
    );

    for (genvar g = 0; g < N_STRB; g++) begin : g_strb
        assign strb[g] = (phase == STRB_PH[g]);
    end

    assign strb_sample = strb[0];
    assign strb_xfer   = strb[1];
    assign strb_direct = strb[2];
    assign strb_sar    = strb[3];

endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk #(
    parameter int unsigned RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ce,
    input logic                start,
    input logic                bypass,
    input logic [RES_BITS-1:0] trial_code,
    input logic                strb_sample,
    input logic                strb_xfer,
    input logic                strb_direct,
    input logic                strb_sar,
    input logic                busy,
    input logic                done,
    input logic [RES_BITS-1:0] result
);

    logic [3:0] strb;
    assign strb = {strb_sar, strb_direct, strb_xfer, strb_sample};

    a_r6_onehot_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(strb) == 1));

    a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (strb == 4'b0000));

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> done);

    a_r7_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce) |=> ($stable(strb) && $stable(trial_code)));

    a_r2_start_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !bypass) |=> strb_sample);

    a_r5_start_to_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bypass) |=> strb_direct);

    a_r3_xfer_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_xfer) |-> $past(strb_sample));

endmodule

bind adc_phase_seq adc_phase_seq_chk #(.RES_BITS(RES_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .bypass(bypass),
    .trial_code(trial_code), .strb_sample(strb_sample), .strb_xfer(strb_xfer),
    .strb_direct(strb_direct), .strb_sar(strb_sar), .busy(busy), .done(done),
    .result(result)
);

// File: tb/adc_phase_seq_tb_top.sv
module adc_phase_seq_tb_top;

    localparam int RB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    len_sel = 2'b00;
    logic          bypass = 1'b0;
    logic          cmp_hi;
    logic [RB-1:0] trial_code, result;
    logic          strb_sample, strb_xfer, strb_direct, strb_sar, busy, done;
    logic [RB-1:0] analog = '0;
    logic [RB-1:0] last_result = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    assign cmp_hi = (analog >= trial_code);

    adc_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .len_sel(len_sel),
        .bypass(bypass), .cmp_hi(cmp_hi), .trial_code(trial_code),
        .strb_sample(strb_sample), .strb_xfer(strb_xfer), .strb_direct(strb_direct),
        .strb_sar(strb_sar), .busy(busy), .done(done), .result(result)
    );

    typedef struct packed {
        logic [1:0]    len;
        logic          byp;
        logic          gate;
        logic [RB-1:0] code;
        logic [7:0]    cyc;
    } vec_t;

    // Expected cycles: no bypass 16+N, bypass max(N,4)+10
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 10'd0,    8'd18},
        '{2'b01, 1'b0, 1'b0, 10'd1023, 8'd20},
        '{2'b10, 1'b0, 1'b0, 10'd512,  8'd24},
        '{2'b11, 1'b0, 1'b0, 10'd511,  8'd32},
        '{2'b00, 1'b1, 1'b0, 10'd341,  8'd14},
        '{2'b01, 1'b1, 1'b0, 10'd682,  8'd14},
        '{2'b10, 1'b1, 1'b0, 10'd5,    8'd18},
        '{2'b11, 1'b1, 1'b0, 10'd1000, 8'd26},
        '{2'b10, 1'b0, 1'b1, 10'd777,  8'd24},
        '{2'b00, 1'b1, 1'b1, 10'd256,  8'd14}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strbs();
        return {strb_sar, strb_direct, strb_xfer, strb_sample};
    endfunction

    // Starts at a negedge with the block idle; returns at the negedge where done is high.
    task automatic run_conv(input logic [1:0] len, input logic byp, input logic gate,
                            input logic [RB-1:0] code, input int exp_cyc, input bit inject);
        int n = 0;
        int i = 0;
        int bad_oh = 0;
        int bad_hold = 0;
        bit sar_seen = 0;
        bit prev_ce = 1;
        logic [3:0] prev_s = '0;
        logic [RB-1:0] prev_t = '0;
        analog  = code;
        len_sel = len;
        bypass  = byp;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        chk(done === 1'b0 && result === last_result, "R11 done low, result held",
            result, last_result);
        if (byp) chk(strb_direct === 1'b1, "R5 bypass begins in direct phase", strbs(), 4);
        else     chk(strb_sample === 1'b1, "R2 begins in sample phase", strbs(), 1);
        while (busy === 1'b1 && i < 2000) begin
            if ($countones(strbs()) != 1) bad_oh++;
            if (!prev_ce && (strbs() != prev_s || trial_code != prev_t)) bad_hold++;
            if (strb_sar && !sar_seen) begin
                sar_seen = 1;
                chk(trial_code == 10'd512, "R8 first trial is MSB", trial_code, 512);
            end
            if (inject && i == 3) begin
                start   = 1'b1;
                len_sel = ~len;
                bypass  = ~byp;
            end else begin
                start = 1'b0;
            end
            ce = gate ? (i % 3 != 1) : 1'b1;
            if (ce) n++;
            prev_ce = ce;
            prev_s  = strbs();
            prev_t  = trial_code;
            i++;
            @(negedge clk);
        end
        start = 1'b0;
        ce    = 1'b1;
        chk(n == exp_cyc, "R3 R4 R5 R10 enabled cycle count", n, exp_cyc);
        chk(bad_oh == 0, "R6 one-hot strobes while busy", bad_oh, 0);
        chk(bad_hold == 0, "R7 no advance without ce", bad_hold, 0);
        chk(done === 1'b1 && busy === 1'b0, "R9 done pulse with busy low", done, 1);
        chk(result == code, "R8 result code", result, code);
        last_result = code;
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk({busy, done, strbs()} == 6'b0 && result == '0, "R1 reset state",
            {busy, done, strbs()}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && strbs() == 4'b0, "R1 R6 idle after reset",
            strbs(), 0);

        for (int v = 0; v < NV; v++) begin
            run_conv(VECS[v].len, VECS[v].byp, VECS[v].gate, VECS[v].code,
                     int'(VECS[v].cyc), 1'b0);
            @(negedge clk);
            chk(done === 1'b0, "R9 done lasts one cycle", done, 0);
            chk(result == VECS[v].code, "R9 result holds", result, VECS[v].code);
        end

        // R10: start with other settings while busy
        run_conv(2'b01, 1'b0, 1'b0, 10'd300, 20, 1'b1);
        @(negedge clk);
        run_conv(2'b00, 1'b1, 1'b1, 10'd900, 14, 1'b1);
        @(negedge clk);

        // R11: start in the done cycle, back to back
        run_conv(2'b11, 1'b1, 1'b0, 10'd123, 26, 1'b0);
        run_conv(2'b00, 1'b0, 1'b0, 10'd1022, 18, 1'b0);
        run_conv(2'b10, 1'b1, 1'b1, 10'd1, 18, 1'b0);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 idle after back-to-back", done, 0);

        // R7: ce held low while idle does not block a start
        ce = 1'b0;
        len_sel = 2'b01;
        bypass = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && strb_sample === 1'b1, "R2 start accepted with ce low",
            busy, 1);
        @(negedge clk);
        chk(strb_sample === 1'b1 && busy === 1'b1, "R7 phase held with ce low",
            strbs(), 1);
        ce = 1'b1;
        while (busy === 1'b1) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule